// File: doc/BRIEF.md
# Interlaced Standard-Definition Raster Timing Generator

This block produces the raster timing for an interlaced standard-definition composite video output. An input selects one of two standards, 525-line or 625-line. The block divides the master clock down to a pixel-rate enable. It counts pixels along each line and lines within each field. From those counts it drives active-low horizontal and vertical sync, an active-video enable and a field-parity flag. All four outputs are registered.

The two fields of a frame do not have the same length. In 525-line mode the vertical front porch is one line longer on the odd field. In 625-line mode the vertical back porch is one line shorter on the odd field. A single field counter with porch lengths chosen by parity therefore yields a frame with an odd number of lines. A downstream encoder uses the pixel enable rhythm together with these outputs to fetch pixels and to shape sync and burst.

Standard selection is sampled only when a frame completes, which keeps a raster from being cut short. Every width, length and the clock divide ratio are parameters. The defaults give the full-size rasters at 13.5 MHz from 108 MHz.

Top module: `sd_raster_timing`

## Requirements
- R1: Each line is, in order: active pixels (H_ACT, 720), front porch (14 in 525-line mode, 20 in 625-line mode), horizontal sync (64) and back porch (60). The line therefore totals 858 or 864 pixels.
- R2: `hsyncN` is low for exactly H_SYNC pixels per line. It falls right after the front porch.
- R3: In 525-line mode (`stdSel`=0) a field is 240 active lines, then a front porch, 3 sync lines and 16 back-porch lines. The front porch is 3 lines on the even field (`fieldOdd`=0) and 4 on the odd field, giving 262 and 263 lines.
- R4: In 625-line mode (`stdSel`=1) a field is 288 active lines, a 2-line front porch and 3 sync lines. The back porch is 20 lines on the even field and 19 on the odd field, giving 313 and 312 lines.
- R5: `vsyncN` is low for whole lines, exactly V_SYNC lines per field. It starts right after the vertical front porch and changes only at a line start.
- R6: `activeEn` is high only when both the pixel count and the line count are in their active regions. It is never high while either sync is low.
- R7: `fieldOdd` toggles exactly when the last pixel of a field completes. Its value selects the porch lengths of the field it marks.
- R8: `stdSel` is adopted only when an odd field completes, which is the frame boundary. A change made at any other time has no effect on the raster until then.
- R9: Counting advances once every CLK_DIV master clocks (8 by default), so each pixel lasts CLK_DIV clocks at the outputs.
- R10: While `rstN` is low the outputs are `hsyncN`=1, `vsyncN`=1, `activeEn`=0 and `fieldOdd`=0. After release the raster starts at the first active pixel of an even field in the standard given by RESET_STD (525-line by default), whatever `stdSel` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (108 MHz by default) |
| rstN | input | 1 | Asynchronous active-low reset |
| stdSel | input | 1 | Standard request: 0 = 525-line, 1 = 625-line |
| hsyncN | output | 1 | Horizontal sync, active low, registered |
| vsyncN | output | 1 | Vertical sync, active low, registered |
| activeEn | output | 1 | Active video region, registered |
| fieldOdd | output | 1 | Field parity, 1 during the odd field, registered |

## Verification
The bench builds the block with a divide ratio of 2 and a shrunken raster. Lines are 16 active pixels, front porch 2 or 3, sync 4 and back porch 3. Fields are 6 or 8 active lines, with sync 2, porches 1/2 against 3 in one standard and 1 against 4/3 in the other. These values keep every region distinct and make a frame a few hundred pixels long. Many fields, several standard switches and a mid-run reset therefore fit in a short run. Each measured field length, porch position and parity is still a direct function of the same parameter set.

// File: rtl/sdvt_pkg.sv
package sdvt_pkg;

  // Strobes and state that the sequencer hands to the counting datapath
  typedef struct packed {
    logic pixEn;     // one master clock per pixel
    logic use625;    // geometry currently in force
    logic oddField;  // parity of the field being counted
  } sdvtStrobe_t;

endpackage

// File: rtl/sdvt_ctrl.sv
module sdvt_ctrl
  import sdvt_pkg::*;
#(
  parameter int CLK_DIV   = 8,
  parameter bit RESET_STD = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        stdSel,
  input  logic        fieldEnd,
  output sdvtStrobe_t strb
);

  logic pixEn;
  logic oddField;
  logic use625;

  generate
    if (CLK_DIV > 1) begin : g_div
      localparam int DW = $clog2(CLK_DIV);
      localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
      logic [DW-1:0] divCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) divCnt <= '0;
        else if (divCnt == DIV_LAST) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end

      assign pixEn = (divCnt == DIV_LAST);

      // R9
      pix_enable_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
        pixEn |=> !pixEn);
    end else begin : g_nodiv
      assign pixEn = 1'b1;
    end
  endgenerate

  // Field parity flips on every field end; the standard is taken only when
  // the odd field (second of the frame) finishes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oddField <= 1'b0;
      use625   <= RESET_STD;
    end else if (fieldEnd) begin
      oddField <= !oddField;
      if (oddField) use625 <= stdSel;
    end
  end

  assign strb = '{pixEn: pixEn, use625: use625, oddField: oddField};

  // R7
  field_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oddField != $past(oddField)) |-> $past(fieldEnd && pixEn));

  // R8
  std_frame_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (use625 != $past(use625)) |-> $past(fieldEnd && oddField));

endmodule

// File: rtl/sdvt_path.sv
module sdvt_path
  import sdvt_pkg::*;
#(
  parameter int H_ACT    = 720,
  parameter int H_SYNC   = 64,
  parameter int H_BP     = 60,
  parameter int H_FP_525 = 14,
  parameter int H_FP_625 = 20,
  parameter int V_ACT_525 = 240,
  parameter int V_ACT_625 = 288,
  parameter int V_SYNC    = 3,
  parameter int V_BP_525  = 16,
  parameter int V_FP_525E = 3,
  parameter int V_FP_525O = 4,
  parameter int V_FP_625  = 2,
  parameter int V_BP_625E = 20,
  parameter int V_BP_625O = 19
) (
  input  logic        clk,
  input  logic        rstN,
  input  sdvtStrobe_t strb,
  output logic        fieldEnd,
  output logic        hsyncN,
  output logic        vsyncN,
  output logic        activeEn,
  output logic        fieldOdd
);

  localparam int H_FP_MAX = (H_FP_525 > H_FP_625) ? H_FP_525 : H_FP_625;
  localparam int H_TOT_MAX = H_ACT + H_FP_MAX + H_SYNC + H_BP;
  localparam int HW = $clog2(H_TOT_MAX + 1);

  localparam int V_ACT_MAX = (V_ACT_525 > V_ACT_625) ? V_ACT_525 : V_ACT_625;
  localparam int V_FP_MAX  = (V_FP_525O > V_FP_525E) ?
                             ((V_FP_525O > V_FP_625) ? V_FP_525O : V_FP_625) :
                             ((V_FP_525E > V_FP_625) ? V_FP_525E : V_FP_625);
  localparam int V_BP_MAX  = (V_BP_625E > V_BP_625O) ?
                             ((V_BP_625E > V_BP_525) ? V_BP_625E : V_BP_525) :
                             ((V_BP_625O > V_BP_525) ? V_BP_625O : V_BP_525);
  localparam int V_TOT_MAX = V_ACT_MAX + V_FP_MAX + V_SYNC + V_BP_MAX;
  localparam int VW = $clog2(V_TOT_MAX + 1);

  localparam logic [HW-1:0] HACT_W  = HW'(H_ACT);
  localparam logic [HW-1:0] HSYN_W  = HW'(H_SYNC);
  localparam logic [HW-1:0] HBP_W   = HW'(H_BP);
  localparam logic [HW-1:0] HFPA_W  = HW'(H_FP_525);
  localparam logic [HW-1:0] HFPB_W  = HW'(H_FP_625);
  localparam logic [VW-1:0] VACTA_W = VW'(V_ACT_525);
  localparam logic [VW-1:0] VACTB_W = VW'(V_ACT_625);
  localparam logic [VW-1:0] VSYN_W  = VW'(V_SYNC);
  localparam logic [VW-1:0] VBPA_W  = VW'(V_BP_525);
  localparam logic [VW-1:0] VFPAE_W = VW'(V_FP_525E);
  localparam logic [VW-1:0] VFPAO_W = VW'(V_FP_525O);
  localparam logic [VW-1:0] VFPB_W  = VW'(V_FP_625);
  localparam logic [VW-1:0] VBPBE_W = VW'(V_BP_625E);
  localparam logic [VW-1:0] VBPBO_W = VW'(V_BP_625O);

  logic [HW-1:0] hCnt, hFp, hSyncBeg, hSyncEnd, hTot;
  logic [VW-1:0] vCnt, vAct, vFp, vBp, vSyncBeg, vSyncEnd, vTot;
  logic lineLast, fieldLast;
  logic inHAct, inVAct, inHSync, inVSync;

  // Line geometry for the standard in force
  always_comb begin
    hFp      = strb.use625 ? HFPB_W : HFPA_W;
    hSyncBeg = HACT_W + hFp;
    hSyncEnd = hSyncBeg + HSYN_W;
    hTot     = hSyncEnd + HBP_W;
  end

  // Field geometry: porch length picked by standard and parity
  always_comb begin
    vAct     = strb.use625 ? VACTB_W : VACTA_W;
    vFp      = strb.use625 ? VFPB_W : (strb.oddField ? VFPAO_W : VFPAE_W);
    vBp      = strb.use625 ? (strb.oddField ? VBPBO_W : VBPBE_W) : VBPA_W;
    vSyncBeg = vAct + vFp;
    vSyncEnd = vSyncBeg + VSYN_W;
    vTot     = vSyncEnd + vBp;
  end

  assign lineLast  = (hCnt == hTot - 1'b1);
  assign fieldLast = (vCnt == vTot - 1'b1);
  assign fieldEnd  = strb.pixEn && lineLast && fieldLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strb.pixEn) begin
      if (lineLast) begin
        hCnt <= '0;
        vCnt <= fieldLast ? '0 : vCnt + 1'b1;
      end else begin
        hCnt <= hCnt + 1'b1;
      end
    end
  end

  assign inHAct  = (hCnt < HACT_W);
  assign inVAct  = (vCnt < vAct);
  assign inHSync = (hCnt >= hSyncBeg) && (hCnt < hSyncEnd);
  assign inVSync = (vCnt >= vSyncBeg) && (vCnt < vSyncEnd);

  // Registered outputs, free of decode glitches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsyncN   <= 1'b1;
      vsyncN   <= 1'b1;
      activeEn <= 1'b0;
      fieldOdd <= 1'b0;
    end else begin
      hsyncN   <= !inHSync;
      vsyncN   <= !inVSync;
      activeEn <= inHAct && inVAct;
      fieldOdd <= strb.oddField;
    end
  end

  // R1
  hcnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    hCnt < hTot);

  // R3
  vcnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    vCnt < vTot);

  // R5
  vsync_line_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vsyncN != $past(vsyncN)) |-> ($past(hCnt) == '0));

  // R6
  active_sync_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeEn |-> (hsyncN && vsyncN));

endmodule

// File: rtl/sd_raster_timing.sv
module sd_raster_timing
  import sdvt_pkg::*;
#(
  parameter int CLK_DIV   = 8,
  parameter bit RESET_STD = 1'b0,
  parameter int H_ACT    = 720,
  parameter int H_SYNC   = 64,
  parameter int H_BP     = 60,
  parameter int H_FP_525 = 14,
  parameter int H_FP_625 = 20,
  parameter int V_ACT_525 = 240,
  parameter int V_ACT_625 = 288,
  parameter int V_SYNC    = 3,
  parameter int V_BP_525  = 16,
  parameter int V_FP_525E = 3,
  parameter int V_FP_525O = 4,
  parameter int V_FP_625  = 2,
  parameter int V_BP_625E = 20,
  parameter int V_BP_625O = 19
) (
  input  logic clk,
  input  logic rstN,
  input  logic stdSel,
  output logic hsyncN,
  output logic vsyncN,
  output logic activeEn,
  output logic fieldOdd
);

  sdvtStrobe_t strb;
  logic fieldEnd;

  sdvt_ctrl #(
    .CLK_DIV  (CLK_DIV),
    .RESET_STD(RESET_STD)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .stdSel  (stdSel),
    .fieldEnd(fieldEnd),
    .strb    (strb)
  );

  sdvt_path #(
    .H_ACT    (H_ACT),
    .H_SYNC   (H_SYNC),
    .H_BP     (H_BP),
    .H_FP_525 (H_FP_525),
    .H_FP_625 (H_FP_625),
    .V_ACT_525(V_ACT_525),
    .V_ACT_625(V_ACT_625),
    .V_SYNC   (V_SYNC),
    .V_BP_525 (V_BP_525),
    .V_FP_525E(V_FP_525E),
    .V_FP_525O(V_FP_525O),
    .V_FP_625 (V_FP_625),
    .V_BP_625E(V_BP_625E),
    .V_BP_625O(V_BP_625O)
  ) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .fieldEnd(fieldEnd),
    .hsyncN  (hsyncN),
    .vsyncN  (vsyncN),
    .activeEn(activeEn),
    .fieldOdd(fieldOdd)
  );

endmodule

// File: tb/sd_raster_timing_tb_top.sv
module sd_raster_timing_tb_top;

  localparam int T_DIV = 2;
  localparam int T_HACT = 16, T_HSYN = 4, T_HBP = 3, T_HFPA = 2, T_HFPB = 3;
  localparam int T_VACTA = 6, T_VACTB = 8, T_VSYN = 2, T_VBPA = 3;
  localparam int T_VFPAE = 1, T_VFPAO = 2, T_VFPB = 1, T_VBPBE = 4, T_VBPBO = 3;

  // Table walked in order: {standard, parity} of each recorded field
  localparam logic [1:0] FIELD_TBL [12] = '{
    2'b00, 2'b01, 2'b00, 2'b01,
    2'b10, 2'b11, 2'b10, 2'b11, 2'b10, 2'b11,
    2'b00, 2'b01
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stdSel = 1'b0;
  logic hsyncN, vsyncN, activeEn, fieldOdd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = !clk;

  sd_raster_timing #(
    .CLK_DIV(T_DIV), .RESET_STD(1'b0),
    .H_ACT(T_HACT), .H_SYNC(T_HSYN), .H_BP(T_HBP),
    .H_FP_525(T_HFPA), .H_FP_625(T_HFPB),
    .V_ACT_525(T_VACTA), .V_ACT_625(T_VACTB), .V_SYNC(T_VSYN),
    .V_BP_525(T_VBPA), .V_FP_525E(T_VFPAE), .V_FP_525O(T_VFPAO),
    .V_FP_625(T_VFPB), .V_BP_625E(T_VBPBE), .V_BP_625O(T_VBPBO)
  ) dut_i (
    .clk(clk), .rstN(rstN), .stdSel(stdSel),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .activeEn(activeEn), .fieldOdd(fieldOdd)
  );

  // Per-field records gathered at the ports
  int recCount;
  int rLines[16], rAct[16], rSync[16], rPre[16], rPer[16], rHAct[16], rFp[16], rHs[16], rPar[16];
  int perClk, actClk, fpClk, hsW, lastPer;
  int fLines, fAct, fSync, fPre, fHAct, fFp, fHs;
  bit prevH, prevF, lineAct;

  always @(negedge clk) begin
    if (!rstN) begin
      recCount = 0; perClk = 0; actClk = 0; fpClk = 0; hsW = 0; lastPer = 0;
      fLines = 0; fAct = 0; fSync = 0; fPre = 0; fHAct = 0; fFp = 0; fHs = 0;
      prevH = 1'b1; prevF = 1'b0; lineAct = 1'b0;
    end else begin
      perClk++;
      if (activeEn) begin actClk++; fpClk = 0; lineAct = 1'b1; end
      else if (hsyncN) fpClk++;
      if (prevH && !hsyncN) begin
        lastPer = perClk; perClk = 0; hsW = 0;
        if (!vsyncN) begin
          if (fSync == 0) fPre = fLines;
          fSync++;
        end
        if (lineAct) begin fAct++; fHAct = actClk; fFp = fpClk; end
        fLines++; actClk = 0; lineAct = 1'b0;
      end
      if (!hsyncN) hsW++;
      if (!prevH && hsyncN) fHs = hsW;
      if (fieldOdd != prevF && recCount < 16) begin
        rLines[recCount] = fLines; rAct[recCount] = fAct; rSync[recCount] = fSync;
        rPre[recCount] = fPre; rPer[recCount] = lastPer; rHAct[recCount] = fHAct;
        rFp[recCount] = fFp; rHs[recCount] = fHs; rPar[recCount] = int'(prevF);
        recCount++;
        fLines = 0; fAct = 0; fSync = 0; fPre = 0;
      end
      prevH = hsyncN; prevF = fieldOdd;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expHFp(input bit s); return s ? T_HFPB : T_HFPA; endfunction
  function automatic int expVAct(input bit s); return s ? T_VACTB : T_VACTA; endfunction
  function automatic int expVFp(input bit s, input bit o);
    return s ? T_VFPB : (o ? T_VFPAO : T_VFPAE);
  endfunction
  function automatic int expVBp(input bit s, input bit o);
    return s ? (o ? T_VBPBO : T_VBPBE) : T_VBPA;
  endfunction

  task automatic checkField(input int i, input bit s, input bit o);
    int eLines, ePer;
    eLines = expVAct(s) + expVFp(s, o) + T_VSYN + expVBp(s, o);
    ePer = T_DIV * (T_HACT + expHFp(s) + T_HSYN + T_HBP);
    // R3 R4 field length and active lines by standard and parity
    check(rLines[i] == eLines, s ? "R4 field lines" : "R3 field lines", rLines[i], eLines);
    check(rAct[i] == expVAct(s), s ? "R4 active lines" : "R3 active lines", rAct[i], expVAct(s));
    // R5 vertical sync length and position
    check(rSync[i] == T_VSYN, "R5 vsync lines", rSync[i], T_VSYN);
    check(rPre[i] == expVAct(s) + expVFp(s, o), "R5 lines before vsync", rPre[i], expVAct(s) + expVFp(s, o));
    // R1 R9 line period in master clocks
    check(rPer[i] == ePer, "R1 line period", rPer[i], ePer);
    // R6 active pixels per active line
    check(rHAct[i] == T_DIV * T_HACT, "R6 active clocks", rHAct[i], T_DIV * T_HACT);
    // R2 sync placement and width
    check(rFp[i] == T_DIV * expHFp(s), "R2 front porch before hsync", rFp[i], T_DIV * expHFp(s));
    check(rHs[i] == T_DIV * T_HSYN, "R2 hsync width", rHs[i], T_DIV * T_HSYN);
    // R7 parity of the field just ended
    check(rPar[i] == int'(o), "R7 field parity", rPar[i], int'(o));
  endtask

  task automatic checkIdle(input string tag);
    // R10 outputs held idle during reset
    check(hsyncN == 1'b1, "R10 hsyncN in reset", int'(hsyncN), 1);
    check(vsyncN == 1'b1, "R10 vsyncN in reset", int'(vsyncN), 1);
    check(activeEn == 1'b0, "R10 activeEn in reset", int'(activeEn), 0);
    check(fieldOdd == 1'b0, "R10 fieldOdd in reset", int'(fieldOdd), 0);
    if (tag.len() == 0) $display("reset check");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (5) @(negedge clk);
    checkIdle("first");
    rstN = 1'b1;

    // R8 mid-frame request (during even field 2) waits for the frame end
    wait (recCount == 2);
    @(negedge clk);
    stdSel = 1'b1;
    // R8 request during odd field 9 takes effect from field 10
    wait (recCount == 9);
    @(negedge clk);
    stdSel = 1'b0;
    wait (recCount == 12);
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      checkField(i, FIELD_TBL[i][1], FIELD_TBL[i][0]);
    end

    // R10 reset mid-run with a 625-line request pending: restart in 525-line mode
    stdSel = 1'b1;
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkIdle("again");
    rstN = 1'b1;
    wait (recCount == 3);
    @(negedge clk);
    checkField(0, 1'b0, 1'b0);
    checkField(1, 1'b0, 1'b1);
    checkField(2, 1'b1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule